// File: doc/BRIEF.md
# Implication-Step 4-Bit Pseudo-Random Shifter

This block holds a 4-bit pseudo-random state and advances it by one position per request. The advance is not done by a parallel register update. A fixed program of 55 primitive steps runs instead, one step per clock. Each step is either a clear of one bit cell or a stateful implication between two cells (`dst <= ~src | dst`). The program works over eight one-bit cells: four state cells, one clock-level cell, and three scratch cells. It first forms the feedback term. It then rewrites each state cell as a level-controlled storage element, with the clock-level cell as the enable.

A user first loads a seed through `load_i`/`seed_i` and then pulses `start_i`. `busy_o` stays high while the program runs. `done_o` pulses once when the new state is on `state_o`. A zero seed would lock the sequence at zero, so it is replaced by a non-zero default. The output sequence is that of a maximal-length Fibonacci shifter: the next value is `{s[0]^s[1], s[3:1]}`. From seed 4 the state visits 2, 9, 12, 6, 11, 5, 10, 13, 14, 15, 7, 3, 1, 8 and then 4 again.

Top module: `imp_lfsr_top`

## Requirements
- R1: While reset is asserted and after it is released, `state_o` equals the default seed 4'b0001, and both `busy_o` and `done_o` are 0.
- R2: A `load_i` pulse while idle places `seed_i` on `state_o` from the next cycle. Bit 3 of the state is the first state cell and bit 0 is the last.
- R3: Loading the value 0 places the default seed 4'b0001 on `state_o` instead.
- R4: A `start_i` pulse while idle raises `busy_o` for exactly 55 consecutive cycles. In the cycle after `busy_o` falls, `done_o` is 1. `done_o` is a single-cycle pulse.
- R5: Each completed shift replaces state s with `{s[0]^s[1], s[3:1]}`. From seed 4 this gives the 15-value cycle 2, 9, 12, 6, 11, 5, 10, 13, 14, 15, 7, 3, 1, 8, 4.
- R6: `load_i` and `start_i` have no effect while `busy_o` is 1. The shift in progress completes with the value computed from the state held at its start, and no further shift follows.
- R7: When `load_i` and `start_i` are both high in an idle cycle, the load takes place and no shift starts.
- R8: A shift runs as a program of two primitives over eight cells. Each program word holds a 1-bit opcode (0 = clear, 1 = imply), a 3-bit source cell index and a 3-bit destination cell index. The clock-level cell is never a destination.
- R9: Whenever `busy_o` is 0, `state_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load `seed_i` into the state cells (idle only) |
| seed_i | input | 4 | Seed value; zero is replaced by the default seed |
| start_i | input | 1 | Begin one 55-step shift (idle only) |
| state_o | output | 4 | Current state, bit 3 = first cell; valid while `busy_o` is 0 |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle pulse when a shift has completed |

## Verification
The hardest situation to reach from the ports is a request that arrives part-way through the program. At that point the state cells hold partial results and the scratch cells hold the feedback. A load that slipped through would then corrupt the result in a way a clean run never shows. The bench waits ten cycles into a running shift and pulses `load_i` and `start_i` together. It then checks that the finished value is the shift of the value held before the run, and that `busy_o` stays low afterwards. The long runs of 30 shifts from several seeds, each compared against a behavioural model, cover every state cell passing through each program slot.

// File: rtl/imp_lfsr_pkg.sv
package imp_lfsr_pkg;

  localparam int CELLS     = 8;
  localparam int STATE_W   = 4;
  localparam int STEPS     = 55;
  localparam int FB_STEPS  = 11;
  localparam int UPD_STEPS = 11;

  typedef enum logic [2:0] {
    CELL_Q1  = 3'd0,
    CELL_Q2  = 3'd1,
    CELL_Q3  = 3'd2,
    CELL_Q4  = 3'd3,
    CELL_CLK = 3'd4,
    CELL_X   = 3'd5,
    CELL_N   = 3'd6,
    CELL_M   = 3'd7
  } cell_e;

  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_IMPLY = 1'b1
  } op_e;

  typedef struct packed {
    op_e   op;
    cell_e src;
    cell_e dst;
  } instr_t;

  function automatic instr_t mk(op_e o, cell_e s, cell_e d);
    instr_t w;
    w.op  = o;
    w.src = s;
    w.dst = d;
    return w;
  endfunction

  // Program word for step i. The feedback Q3^Q4 is built into M during
  // steps 0..10. Four latch updates follow (Q4<-Q3, Q3<-Q2, Q2<-Q1,
  // Q1<-M), each computing q' = (C & d) | (~C & q) with X and N as scratch.
  function automatic instr_t prog_word(int i);
    instr_t w;
    int     k;
    int     j;
    cell_e  q;
    cell_e  d;
    w = mk(OP_CLEAR, CELL_X, CELL_X);
    if (i < FB_STEPS) begin
      case (i)
        0:  w = mk(OP_CLEAR, CELL_M,  CELL_M);
        1:  w = mk(OP_IMPLY, CELL_Q4, CELL_M);
        2:  w = mk(OP_CLEAR, CELL_X,  CELL_X);
        3:  w = mk(OP_IMPLY, CELL_Q3, CELL_X);
        4:  w = mk(OP_CLEAR, CELL_N,  CELL_N);
        5:  w = mk(OP_IMPLY, CELL_Q4, CELL_N);
        6:  w = mk(OP_IMPLY, CELL_X,  CELL_N);
        7:  w = mk(OP_IMPLY, CELL_M,  CELL_X);
        8:  w = mk(OP_CLEAR, CELL_M,  CELL_M);
        9:  w = mk(OP_IMPLY, CELL_X,  CELL_M);
        default: w = mk(OP_IMPLY, CELL_N, CELL_M);
      endcase
    end else if (i < STEPS) begin
      k = (i - FB_STEPS) / UPD_STEPS;
      j = (i - FB_STEPS) % UPD_STEPS;
      q = cell_e'(3'(3 - k));
      d = (k == 3) ? CELL_M : cell_e'(3'(2 - k));
      case (j)
        0:  w = mk(OP_CLEAR, CELL_N,   CELL_N);
        1:  w = mk(OP_IMPLY, CELL_CLK, CELL_N);
        2:  w = mk(OP_CLEAR, CELL_X,   CELL_X);
        3:  w = mk(OP_IMPLY, q,        CELL_X);
        4:  w = mk(OP_IMPLY, CELL_N,   CELL_X);
        5:  w = mk(OP_CLEAR, q,        q);
        6:  w = mk(OP_IMPLY, CELL_X,   q);
        7:  w = mk(OP_CLEAR, CELL_X,   CELL_X);
        8:  w = mk(OP_IMPLY, CELL_CLK, CELL_X);
        9:  w = mk(OP_IMPLY, d,        CELL_X);
        default: w = mk(OP_IMPLY, CELL_X, q);
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/imp_rst_sync.sv
module imp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/imp_prog_rom.sv
module imp_prog_rom
  import imp_lfsr_pkg::*;
#(
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic [STEP_W-1:0] step_i,
  output instr_t            instr_o
);

  localparam int SLOTS = 2 ** STEP_W;

  instr_t prog [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_word
    if (g < STEPS) begin : g_used
      assign prog[g] = prog_word(g);
    end else begin : g_pad
      assign prog[g] = mk(OP_CLEAR, CELL_X, CELL_X);
    end
  end

  assign instr_o = prog[step_i];

endmodule

// File: rtl/imp_step_seq.sv
module imp_step_seq
  import imp_lfsr_pkg::*;
#(
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_go_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic              busy_q, busy_nx;
  logic              done_q, done_nx;
  logic [STEP_W-1:0] cnt_q,  cnt_nx;
  logic              cnt_en;

  assign last_o = busy_q && (cnt_q == LAST);
  assign cnt_en = start_go_i || busy_q;

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    done_nx = 1'b0;
    if (!busy_q) begin
      if (start_go_i) begin
        busy_nx = 1'b1;
        cnt_nx  = '0;
      end
    end else if (last_o) begin
      busy_nx = 1'b0;
      done_nx = 1'b1;
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign busy_o = busy_q;
  assign step_o = cnt_q;
  assign done_o = done_q;

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST));

  // R4
  start_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_go_i && !busy_q) |=> (busy_q && cnt_q == '0));

  // R4
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/imp_cell_bank.sv
module imp_cell_bank
  import imp_lfsr_pkg::*;
#(
  parameter logic [STATE_W-1:0] RESET_STATE = 4'b0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [STATE_W-1:0] load_val_i,
  input  logic               arm_en_i,
  input  logic               step_en_i,
  input  instr_t             instr_i,
  output logic [STATE_W-1:0] state_o
);

  function automatic logic [CELLS-1:0] with_state(logic [CELLS-1:0] base,
                                                  logic [STATE_W-1:0] s);
    logic [CELLS-1:0] r;
    r = base;
    for (int b = 0; b < STATE_W; b++) r[b] = s[STATE_W-1-b];
    return r;
  endfunction

  localparam logic [CELLS-1:0] CELLS_RST =
    with_state(CELLS'(1) << CELL_CLK, RESET_STATE);

  logic [CELLS-1:0] cells_q, cells_nx;
  logic             cells_en;
  logic             src_bit, dst_bit;

  assign cells_en = load_en_i || arm_en_i || step_en_i;
  assign src_bit  = cells_q[instr_i.src];
  assign dst_bit  = cells_q[instr_i.dst];

  always_comb begin
    cells_nx = cells_q;
    if (load_en_i) cells_nx = with_state(cells_nx, load_val_i);
    if (arm_en_i)  cells_nx[CELL_CLK] = 1'b1;
    if (step_en_i) begin
      if (instr_i.op == OP_CLEAR) cells_nx[instr_i.dst] = 1'b0;
      else                        cells_nx[instr_i.dst] = ~src_bit | dst_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cells_q <= CELLS_RST;
    else if (cells_en) cells_q <= cells_nx;
  end

  for (genvar b = 0; b < STATE_W; b++) begin : g_out
    assign state_o[STATE_W-1-b] = cells_q[b];
  end

  // R8
  clk_cell_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i |-> (instr_i.dst != CELL_CLK));

  // R8
  imply_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && instr_i.op == OP_IMPLY && dst_bit) |=> cells_q[$past(instr_i.dst)]);

  // R8
  clear_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_en_i && instr_i.op == OP_CLEAR) |=> !cells_q[$past(instr_i.dst)]);

endmodule

// File: rtl/imp_lfsr_top.sv
module imp_lfsr_top
  import imp_lfsr_pkg::*;
#(
  parameter logic [STATE_W-1:0] DEFAULT_SEED = 4'b0001,
  parameter int                 SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               start_i,
  output logic [STATE_W-1:0] state_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int STEP_W = $clog2(STEPS);

  logic               rst_sync_n;
  logic               busy, last;
  logic               load_go, start_go;
  logic [STEP_W-1:0]  step;
  logic [STATE_W-1:0] seed_eff;
  instr_t             instr;

  assign load_go  = load_i && !busy;
  assign start_go = start_i && !busy && !load_i;
  assign seed_eff = (seed_i == '0) ? DEFAULT_SEED : seed_i;

  imp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  imp_step_seq #(.STEP_W(STEP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .start_go_i (start_go),
    .busy_o     (busy),
    .last_o     (last),
    .step_o     (step),
    .done_o     (done_o)
  );

  imp_prog_rom #(.STEP_W(STEP_W)) u_rom (
    .step_i  (step),
    .instr_o (instr)
  );

  imp_cell_bank #(.RESET_STATE(DEFAULT_SEED)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_en_i  (load_go),
    .load_val_i (seed_eff),
    .arm_en_i   (start_go),
    .step_en_i  (busy),
    .instr_i    (instr),
    .state_o    (state_o)
  );

  assign busy_o = busy;

  // R9
  no_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !busy |-> (state_o != '0));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (busy && !last) |=> busy);

  // R6
  busy_no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    last |=> !busy);

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!busy && load_i) |=> !busy);

endmodule

// File: tb/sim_imp_lfsr_top.sv
module sim_imp_lfsr_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       load_i;
  logic [3:0] seed_i;
  logic       start_i;
  logic [3:0] state_o;
  logic       busy_o;
  logic       done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  imp_lfsr_top u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .start_i (start_i),
    .state_o (state_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  function automatic logic [3:0] ref_next(logic [3:0] s);
    return {s[0] ^ s[1], s[3:1]};
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic load_seed(logic [3:0] v);
    @(negedge clk_i);
    load_i = 1'b1;
    seed_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // One shift; returns the number of busy cycles and checks the done pulse.
  task automatic do_shift(output int cycles);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cycles = 0;
    while (busy_o && cycles < 200) begin
      cycles++;
      @(negedge clk_i);
    end
    chk("R4 done high after busy falls", done_o, 1);
    @(negedge clk_i);
    chk("R4 done is one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    rst_ni  = 1'b0;
    load_i  = 1'b0;
    start_i = 1'b0;
    seed_i  = 4'h0;
    repeat (3) @(negedge clk_i);
    chk("R1 state in reset", state_o, 1);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 state after reset", state_o, 1);
    chk("R1 busy after reset", busy_o, 0);
  endtask

  task automatic t_load();
    load_seed(4'hA);
    chk("R2 loaded seed A", state_o, 4'hA);
    load_seed(4'h5);
    chk("R2 loaded seed 5", state_o, 4'h5);
  endtask

  task automatic t_zero_seed();
    load_seed(4'h0);
    chk("R3 zero seed replaced", state_o, 1);
    chk("R9 state non-zero after zero load", (state_o != 0), 1);
  endtask

  task automatic t_order();
    logic [3:0] seq [15] = '{4'd2, 4'd9, 4'd12, 4'd6, 4'd11, 4'd5, 4'd10,
                             4'd13, 4'd14, 4'd15, 4'd7, 4'd3, 4'd1, 4'd8, 4'd4};
    int cyc;
    load_seed(4'd4);
    for (int i = 0; i < 15; i++) begin
      do_shift(cyc);
      chk("R5 R8 sequence from seed 4", state_o, seq[i]);
    end
  endtask

  task automatic t_run30(logic [3:0] seed);
    logic [3:0] exp_s;
    int cyc;
    load_seed(seed);
    exp_s = seed;
    for (int i = 0; i < 30; i++) begin
      do_shift(cyc);
      exp_s = ref_next(exp_s);
      chk("R4 busy length", cyc, 55);
      chk("R5 shift against model", state_o, exp_s);
      chk("R9 state non-zero", (state_o != 0), 1);
    end
  endtask

  task automatic t_busy_ignore();
    int waited;
    load_seed(4'h6);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R6 still busy before pulse", busy_o, 1);
    load_i  = 1'b1;
    seed_i  = 4'h3;
    start_i = 1'b1;
    @(negedge clk_i);
    load_i  = 1'b0;
    start_i = 1'b0;
    waited = 0;
    while (busy_o && waited < 200) begin
      waited++;
      @(negedge clk_i);
    end
    chk("R6 result ignores mid-run load", state_o, ref_next(4'h6));
    @(negedge clk_i);
    chk("R6 no new shift after run", busy_o, 0);
    chk("R6 state unchanged after run", state_o, ref_next(4'h6));
  endtask

  task automatic t_load_start();
    load_seed(4'h7);
    @(negedge clk_i);
    load_i  = 1'b1;
    seed_i  = 4'h9;
    start_i = 1'b1;
    @(negedge clk_i);
    load_i  = 1'b0;
    start_i = 1'b0;
    chk("R7 load taken", state_o, 4'h9);
    chk("R7 no shift started", busy_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R7 still idle", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_zero_seed();
    t_order();
    t_run30(4'h1);
    t_run30(4'h7);
    t_run30(4'hE);
    t_busy_ignore();
    t_load_start();
    summary();
    $finish;
  end

endmodule